// File: doc/BRIEF.md
# Rotate-Through-Carry-Left Execution Unit

This unit rotates an operand of 8, 16, 32 or 64 bits to the left. The carry flag is treated as one more bit of the rotation ring, so the ring of an N-bit operand is N+1 bits long. Each step moves every bit one position toward the more significant end. The top bit of the operand moves into the carry, and the old carry moves into bit 0. The unit returns the rotated operand, the new carry flag and an overflow flag. The overflow flag is defined only for a rotate by one.

A request is presented for one cycle with `in_valid` high. The result appears on the outputs one clock later with `out_valid` high. First the count is cut to a bit field whose width depends on the operand size. Then the count is reduced modulo the ring length. Because of this, a narrow operand can go round its ring more than once inside the allowed count range.

Top module: `rcl_unit`

## Requirements
- R1: Each rotate step moves every operand bit one position toward the most significant end, and the operand's top bit (bit N-1) becomes the new carry.
- R2: Each rotate step moves the incoming carry into bit 0 of the result.
- R3: For the size codes 0 (8 bit), 1 (16 bit) and 2 (32 bit), only `in_count[4:0]` is used and `in_count[7:5]` is ignored.
- R4: For size code 3 (64 bit), only `in_count[5:0]` is used and `in_count[7:6]` is ignored.
- R5: The number of steps applied is the masked count modulo N+1. For example, an 8-bit operand rotated by 10 gives the same result as a rotate by 1.
- R6: A masked count of 0, or a masked count that is a multiple of N+1, returns the operand and carry unchanged.
- R7: When the masked count is exactly 1, `out_ovf_valid` is 1 and `out_ovf` is the XOR of the new carry and bit N-1 of the result.
- R8: For any other masked count, or when no request is presented, `out_ovf_valid` is 0 and `out_ovf` keeps its previous value.
- R9: `out_valid` follows `in_valid` one cycle later, and all results are registered. While `in_valid` is low, `out_data` and `out_carry` keep their values.
- R10: Result bits at positions N and above are always 0, whatever `in_data` holds there.
- R11: After a synchronous active-low reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_data | input | 64 | Operand; bits at positions N and above are ignored |
| in_size | input | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 bits |
| in_count | input | 8 | Rotate count before masking |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result registers were loaded in the previous cycle |
| out_data | output | 64 | Rotated operand, zero-extended |
| out_carry | output | 1 | New carry flag |
| out_ovf | output | 1 | Overflow flag, held unless updated |
| out_ovf_valid | output | 1 | Overflow flag was updated by a rotate by one |

## Verification
The only state this unit holds is its output registers, so a wrong internal value shows at the ports one cycle after the request that caused it. A wrong masking or modulo shows as a rotation by the wrong number of steps. This is exposed by counts that sit just above a mask boundary, or just above a multiple of N+1. A wrong overflow hold shows as `out_ovf` changing after a request whose count is not 1. A wrong carry path shows in bit 0 of the result, or in `out_carry`, on the very next cycle.

// File: rtl/rcl_pkg.sv
// Package: shared types for the rotate-through-carry unit.
// Assumes four operand sizes, each twice the width of the one before, starting at 8 bits.
package rcl_pkg;
    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } rcl_size_e;

    localparam int NUM_SIZES = 4;
    localparam int BASE_W    = 8;
endpackage

// File: rtl/rcl_count_prep.sv
// Count preparation: masks the raw count to the width-dependent field, then
// reduces it modulo the ring length (operand width + 1).
// Assumes EFF_W is wide enough to hold 64.
module rcl_count_prep
    import rcl_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int EFF_W = 7
) (
    input  logic [CNT_W-1:0] count_i,
    input  rcl_size_e        size_i,
    output logic [EFF_W-1:0] eff_o,
    output logic             unit_o
);
    logic [5:0] masked;

    // Mask the count and reduce it modulo the ring length for the selected size.
    always_comb begin
        masked = (size_i == SZ_D) ? count_i[5:0] : {1'b0, count_i[4:0]};
        unit_o = (masked == 6'd1);
        case (size_i)
            SZ_B:    eff_o = EFF_W'(masked % 6'd9);
            SZ_H:    eff_o = EFF_W'(masked % 6'd17);
            default: eff_o = EFF_W'(masked);
        endcase
    end
endmodule

// File: rtl/rcl_ring_rotate.sv
// Ring rotator: builds one (W+1)-bit ring {carry, operand} for each operand
// size, rotates it left by the effective count, and selects the lane that
// matches the size. Assumes DATA_W equals the widest lane (64) and eff_i <= W.
module rcl_ring_rotate
    import rcl_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int EFF_W  = 7
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              carry_i,
    input  rcl_size_e         size_i,
    input  logic [EFF_W-1:0]  eff_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic              msb_o
);
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int W = BASE_W << g;
        logic [W:0]        ring;
        logic [2*W+1:0]    shifted;
        logic [DATA_W-1:0] lane_res;
        logic              lane_c;
        logic              lane_msb;

        // Rotate a doubled copy of the ring; the top W+1 bits are the rotated ring.
        always_comb begin
            ring              = {carry_i, data_i[W-1:0]};
            shifted           = {ring, ring} << eff_i;
            lane_res          = '0;
            lane_res[W-1:0]   = shifted[2*W:W+1];
            lane_c            = shifted[2*W+1];
            lane_msb          = shifted[2*W];
        end
    end

    // Pick the lane for the requested operand size.
    always_comb begin
        case (size_i)
            SZ_B: begin
                res_o = g_lane[0].lane_res; carry_o = g_lane[0].lane_c; msb_o = g_lane[0].lane_msb;
            end
            SZ_H: begin
                res_o = g_lane[1].lane_res; carry_o = g_lane[1].lane_c; msb_o = g_lane[1].lane_msb;
            end
            SZ_W: begin
                res_o = g_lane[2].lane_res; carry_o = g_lane[2].lane_c; msb_o = g_lane[2].lane_msb;
            end
            default: begin
                res_o = g_lane[3].lane_res; carry_o = g_lane[3].lane_c; msb_o = g_lane[3].lane_msb;
            end
        endcase
    end
endmodule

// File: rtl/rcl_unit.sv
// Rotate-through-carry-left execution unit (top).
// Prepares the count, rotates the carry ring, derives the overflow flag for
// single-step rotates, and registers everything with one cycle of latency.
// Assumes a synchronous active-low reset and DATA_W = 64.
module rcl_unit
    import rcl_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        in_size,
    input  logic [CNT_W-1:0]  in_count,
    input  logic              in_carry,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_carry,
    output logic              out_ovf,
    output logic              out_ovf_valid
);
    localparam int EFF_W = $clog2(DATA_W + 1) + 1;

    rcl_size_e         size_e;
    logic [EFF_W-1:0]  eff_cnt;
    logic              unit_cnt;
    logic [DATA_W-1:0] rot_res;
    logic              rot_carry;
    logic              rot_msb;

    assign size_e = rcl_size_e'(in_size);

    rcl_count_prep #(.CNT_W(CNT_W), .EFF_W(EFF_W)) i_prep (
        .count_i (in_count),
        .size_i  (size_e),
        .eff_o   (eff_cnt),
        .unit_o  (unit_cnt)
    );

    rcl_ring_rotate #(.DATA_W(DATA_W), .EFF_W(EFF_W)) i_rot (
        .data_i  (in_data),
        .carry_i (in_carry),
        .size_i  (size_e),
        .eff_i   (eff_cnt),
        .res_o   (rot_res),
        .carry_o (rot_carry),
        .msb_o   (rot_msb)
    );

    // Register the result and flags; overflow is updated only for a single-step rotate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_data      <= '0;
            out_carry     <= 1'b0;
            out_ovf       <= 1'b0;
            out_ovf_valid <= 1'b0;
        end else begin
            out_valid     <= in_valid;
            out_ovf_valid <= in_valid & unit_cnt;
            if (in_valid) begin
                out_data  <= rot_res;
                out_carry <= rot_carry;
                if (unit_cnt) begin
                    out_ovf <= rot_carry ^ rot_msb;
                end
            end
        end
    end

    // R9: a request yields a valid result one cycle later
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: without a request the result holds and is not flagged valid
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_carry)));

    // R8: overflow flag holds unless a single-step rotate was requested
    p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && unit_cnt) |=> ($stable(out_ovf) && !out_ovf_valid));

    // R6: a zero masked 64-bit count returns operand and carry unchanged
    p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'd3 && in_count[5:0] == 6'd0) |=>
        (out_data == $past(in_data) && out_carry == $past(in_carry)));

    // R1, R2: a one-step 64-bit rotate moves the top bit to carry and carry to bit 0
    p_one_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'd3 && in_count[5:0] == 6'd1) |=>
        (out_carry == $past(in_data[DATA_W-1]) && out_data[0] == $past(in_carry)));

    // R7: a one-step rotate reports overflow as new carry XOR result msb
    p_of_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'd3 && in_count[5:0] == 6'd1) |=>
        (out_ovf_valid && out_ovf == (out_carry ^ out_data[DATA_W-1])));

    // R10: byte results carry no bits above position 7
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'd0) |=> (out_data[DATA_W-1:8] == '0));
endmodule

// File: tb/test_rcl_unit.sv
module test_rcl_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    typedef struct packed {
        logic [63:0] d;
        logic [1:0]  sz;
        logic [7:0]  cnt;
        logic        ci;
        logic [63:0] ed;
        logic        ec;
        logic        eov;
        logic        eof;
    } vec_t;

    // Size codes: 0=8, 1=16, 2=32, 3=64 bits
    localparam vec_t TBL [NV] = '{
        '{64'hFFFF_FFFF_FFFF_FF81, 2'd0, 8'd1,    1'b0, 64'h02,                 1'b1, 1'b1, 1'b1}, // R1 R2 R7 R10
        '{64'h0000_0000_0000_8000, 2'd1, 8'd17,   1'b0, 64'h8000,               1'b0, 1'b0, 1'b0}, // R5 R6
        '{64'h0000_0000_0000_005A, 2'd0, 8'd9,    1'b1, 64'h5A,                 1'b1, 1'b0, 1'b0}, // R5 R6
        '{64'h0000_0000_0000_005A, 2'd0, 8'd10,   1'b1, 64'hB5,                 1'b0, 1'b0, 1'b0}, // R5 R2
        '{64'h0000_0000_8000_0000, 2'd2, 8'd1,    1'b1, 64'h1,                  1'b1, 1'b1, 1'b1}, // R1 R7
        '{64'h8000_0000_0000_0000, 2'd3, 8'h40,   1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0}, // R4 R6
        '{64'h4000_0000_0000_0000, 2'd3, 8'h41,   1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b1}, // R4 R7
        '{64'h0000_0000_0000_0001, 2'd2, 8'h21,   1'b0, 64'h2,                  1'b0, 1'b1, 1'b0}, // R3 R7
        '{64'h0000_0000_0000_1234, 2'd1, 8'd4,    1'b1, 64'h2348,               1'b1, 1'b0, 1'b0}, // R1 R2
        '{64'h0000_0000_0000_0001, 2'd3, 8'd63,   1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0}, // R4 R5
        '{64'h0000_0000_0000_00F0, 2'd0, 8'd31,   1'b0, 64'h07,                 1'b1, 1'b0, 1'b0}, // R5
        '{64'h0000_0000_0000_00FF, 2'd0, 8'hE0,   1'b1, 64'hFF,                 1'b1, 1'b0, 1'b0}  // R3 R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [1:0]  in_size = '0;
    logic [7:0]  in_count = '0;
    logic        in_carry = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_carry;
    logic        out_ovf;
    logic        out_ovf_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcl_unit i_rcl_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_size(in_size), .in_count(in_count), .in_carry(in_carry),
        .out_valid(out_valid), .out_data(out_data), .out_carry(out_carry),
        .out_ovf(out_ovf), .out_ovf_valid(out_ovf_valid)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one request at a falling edge and sample after the next rising edge.
    task automatic apply(input logic [63:0] d, input logic [1:0] sz, input logic [7:0] cnt, input logic ci);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_size = sz; in_count = cnt; in_carry = ci;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 out_valid", 64'(out_valid), 64'd0);
        chk("R11 out_data", out_data, 64'd0);
        chk("R11 out_carry", 64'(out_carry), 64'd0);
        chk("R11 out_ovf", 64'(out_ovf), 64'd0);
        chk("R11 out_ovf_valid", 64'(out_ovf_valid), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].d, TBL[i].sz, TBL[i].cnt, TBL[i].ci);
            chk($sformatf("R9 row %0d valid", i), 64'(out_valid), 64'd1);
            chk($sformatf("R1 R2 R5 row %0d data", i), out_data, TBL[i].ed);
            chk($sformatf("R1 R3 R4 row %0d carry", i), 64'(out_carry), 64'(TBL[i].ec));
            chk($sformatf("R7 R8 row %0d ovf_valid", i), 64'(out_ovf_valid), 64'(TBL[i].eov));
            if (TBL[i].eov) chk($sformatf("R7 row %0d ovf", i), 64'(out_ovf), 64'(TBL[i].eof));
        end

        // R9: idle cycle keeps data and drops valid
        @(negedge clk);
        chk("R9 idle valid", 64'(out_valid), 64'd0);
        chk("R9 idle data held", out_data, TBL[NV-1].ed);

        // R8: overflow held across a multi-step rotate
        apply(TBL[0].d, TBL[0].sz, TBL[0].cnt, TBL[0].ci);
        chk("R7 ovf set", 64'(out_ovf), 64'd1);
        apply(64'h11, 2'd0, 8'd3, 1'b0);
        chk("R8 ovf held high", 64'(out_ovf), 64'd1);
        chk("R8 ovf_valid low", 64'(out_ovf_valid), 64'd0);
        chk("R1 three-step byte", out_data, 64'h88);
        apply(TBL[7].d, TBL[7].sz, TBL[7].cnt, TBL[7].ci);
        chk("R7 ovf cleared", 64'(out_ovf), 64'd0);
        apply(64'hABCD, 2'd1, 8'd0, 1'b1);
        chk("R8 ovf held low", 64'(out_ovf), 64'd0);
        chk("R6 zero count data", out_data, 64'hABCD);
        chk("R6 zero count carry", 64'(out_carry), 64'd1);

        // R11: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 data after reset", out_data, 64'd0);
        chk("R11 carry after reset", 64'(out_carry), 64'd0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule